// File: doc/BRIEF.md
# Quarter-Wave Three-Phase Waveform Sequencer

This block produces three phase-shifted, amplitude-scaled sample streams for a three-phase inverter modulator. The streams come from a quarter-cycle sine table, which is computed when the design is elaborated. A free-running clock divider and a 512-tick triangle carrier set the sampling rate. A fractional phase accumulator advances a 1536-position cycle index on carrier ticks, and this sets the output (power) frequency. The full cycle is rebuilt by mirroring the table for the second quarter and negating the first half-cycle for the second half.

The yellow phase trails red by one third of a cycle and blue trails red by two thirds. A direction input makes the index count down, so the sequence reverses without any jump in phase. An active-low counter-reset input parks the index at 0°. Three zero-phase marker outputs and a sampling-sync output give speed feedback. A sample-and-hold latches each phase's level at both triangle peaks. A comparator against the triangle then produces a raw PWM bit per phase, with no dead time.

Top module: `wsq_sequencer`

## Requirements
- R1: While `rst_n` or `cnt_rst_n` is low, the cycle index and fractional accumulator are held at 0, `wss` does not toggle, and red stays at sample 0, so red's raw PWM has 50% duty. Reset also clears `pwm_raw` to 0.
- R2: On each carrier tick, `freq_word << min(frs_code,6)` is added to a 19-bit fractional accumulator. Each carry out moves the index one position. Over K ticks, the number of steps is K·inc/2^19 within one.
- R3: A carrier tick occurs once every 2^min(cfs_code,5) clocks. The triangle takes 512 ticks per period: it rises 0..255 and then falls 255..0.
- R4: For a phase position p (0..1535), the folded position is q = p mod 768. The table address is q when q < 384, and 767−q otherwise. The table value is round(255·sin(90°·a/384)).
- R5: Positions 768..1535 give the negated magnitude of positions 0..767.
- R6: Red uses the index p. Yellow uses (p−512) mod 1536 and blue uses (p−1024) mod 1536.
- R7: With `dir_rev`=0 the index steps +1 and wraps 1535→0. With `dir_rev`=1 it steps −1 and wraps 0→1535. Changing direction never moves the index by more than one step.
- R8: The output sample is ±floor(mag·A/255), where A = {overmod, amp_word} (0..511), so overmodulation reaches up to 511.
- R9: `zpp[k]` is high exactly when phase k's position is 1024 or more (one third high, two thirds low). Bit 0 is red, bit 1 is yellow and bit 2 is blue.
- R10: `wss` toggles once for every index step and at no other time.
- R11: At each triangle peak, each phase latches the level L = clamp(floor((s+256)/2), 0, 255). `pwm_raw[k]` is high when L exceeds the triangle value, so it is high for 2L of every 512 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfs_code | input | 3 | Clock divide code, n = 2^code |
| frs_code | input | 3 | Range multiplier code, m = 2^code |
| freq_word | input | 12 | Frequency word within the range |
| dir_rev | input | 1 | 1 = reverse phase sequence |
| amp_word | input | 8 | Amplitude scale |
| overmod | input | 1 | Ninth (MSB) amplitude bit |
| cnt_rst_n | input | 1 | Counter reset, active low |
| samp_red | output | 10 | Signed red sample |
| samp_yel | output | 10 | Signed yellow sample |
| samp_blu | output | 10 | Signed blue sample |
| pwm_raw | output | 3 | Raw PWM bits {blue, yellow, red} |
| zpp | output | 3 | Zero-phase markers {blue, yellow, red} |
| wss | output | 1 | Sampling-sync toggle |

## Verification
On every cycle, assertions check the following: the index moves by at most one position in the commanded direction, counter reset parks it, `wss` toggles exactly when the index moves, exactly one zero-phase marker is high, every sample stays within the commanded amplitude, and samples are latched only at triangle extremes. Only the scenarios can show the rest. They sweep the whole cycle in both directions against table values computed in the bench. They check step rates under several divide and range codes, including the clamped codes. They also measure PWM duty at frozen positions, which shows the peak sampling and the comparator working together.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

    // Quarter-cycle sine sample, full scale maxv
    function automatic int quarter_sample(input int a, input int quart, input int maxv);
        real v;
        v = real'(maxv) * $sin(1.5707963267948966 * real'(a) / real'(quart));
        return $rtoi(v + 0.5);
    endfunction

endpackage

// File: rtl/wsq_carrier.sv
module wsq_carrier #(
    parameter int CODE_W  = 3,
    parameter int CFS_MAX = 5,
    parameter int TRI_W   = 8,
    localparam int DIVW   = (CFS_MAX > 0) ? CFS_MAX : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cfs,
    output logic              tick,
    output logic              peak,
    output logic [TRI_W-1:0]  tri_val
);

    typedef struct packed {
        logic [DIVW-1:0] div;
        logic [TRI_W:0]  ph;
        logic            tick;
        logic            peak;
    } car_t;

    car_t cur_q, nxt_d;
    logic [CODE_W-1:0] code;
    logic [DIVW-1:0]   lim;
    logic              wrap;

    always_comb begin
        nxt_d = cur_q;
        code  = (cfs > CODE_W'(CFS_MAX)) ? CODE_W'(CFS_MAX) : cfs;
        lim   = DIVW'((32'd1 << code) - 32'd1);
        wrap  = (cur_q.div >= lim);
        nxt_d.div  = wrap ? '0 : cur_q.div + 1'b1;
        nxt_d.tick = wrap;
        nxt_d.ph   = wrap ? cur_q.ph + 1'b1 : cur_q.ph;
        nxt_d.peak = wrap && (cur_q.ph[TRI_W-1:0] == '1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign tick    = cur_q.tick;
    assign peak    = cur_q.peak;
    assign tri_val = cur_q.ph[TRI_W] ? ~cur_q.ph[TRI_W-1:0] : cur_q.ph[TRI_W-1:0];

    // Samples are taken only at the triangle turning points
    assert_peak_extreme_R11: assert property (@(posedge clk) disable iff (!rst_n)
        peak |-> (tri_val == '0 || tri_val == '1));

endmodule

// File: rtl/wsq_phase.sv
module wsq_phase #(
    parameter int PFS_W   = 12,
    parameter int CODE_W  = 3,
    parameter int FRS_MAX = 6,
    parameter int POS     = 1536,
    parameter int CAR_LOG = 9,
    parameter int QTR_LOG = 2,
    localparam int IDX_W  = $clog2(POS),
    localparam int FRAC_W = PFS_W + CAR_LOG - QTR_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] frs,
    input  logic [PFS_W-1:0]  pfs,
    input  logic              dir_rev,
    input  logic              cnt_rst_n,
    output logic [IDX_W-1:0]  idx,
    output logic              wss
);

    typedef struct packed {
        logic [FRAC_W-1:0] acc;
        logic [IDX_W-1:0]  idx;
        logic              wss;
    } ph_t;

    ph_t cur_q, nxt_d;
    logic [CODE_W-1:0] code;
    logic [FRAC_W-1:0] inc;
    logic [FRAC_W:0]   sum;

    always_comb begin
        nxt_d = cur_q;
        code  = (frs > CODE_W'(FRS_MAX)) ? CODE_W'(FRS_MAX) : frs;
        inc   = FRAC_W'(pfs) << code;
        sum   = {1'b0, cur_q.acc} + {1'b0, inc};
        if (!cnt_rst_n) begin
            nxt_d.acc = '0;
            nxt_d.idx = '0;
        end else if (tick) begin
            nxt_d.acc = sum[FRAC_W-1:0];
            if (sum[FRAC_W]) begin
                nxt_d.wss = ~cur_q.wss;
                if (dir_rev)
                    nxt_d.idx = (cur_q.idx == '0) ? IDX_W'(POS - 1) : cur_q.idx - 1'b1;
                else
                    nxt_d.idx = (cur_q.idx == IDX_W'(POS - 1)) ? '0 : cur_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign idx = cur_q.idx;
    assign wss = cur_q.wss;

    assert_cnt_rst_park_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_rst_n |=> (idx == '0));

    assert_fwd_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rst_n && !dir_rev) |=> (idx == $past(idx) ||
            idx == (($past(idx) == IDX_W'(POS - 1)) ? '0 : $past(idx) + 1'b1)));

    assert_rev_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rst_n && dir_rev) |=> (idx == $past(idx) ||
            idx == (($past(idx) == '0) ? IDX_W'(POS - 1) : $past(idx) - 1'b1)));

    assert_wss_tracks_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst_n |=> ($stable(idx) == $stable(wss)));

endmodule

// File: rtl/wsq_shaper.sv
module wsq_shaper #(
    parameter int QUART  = 384,
    parameter int POS    = 1536,
    parameter int SAMP_W = 8,
    parameter int A_W    = 9,
    localparam int IDX_W = $clog2(POS),
    localparam int AW    = $clog2(QUART),
    localparam int OUT_W = A_W + 1,
    localparam int P_W   = SAMP_W + A_W
) (
    input  logic [IDX_W-1:0]        pos,
    input  logic [A_W-1:0]          amp,
    output logic signed [OUT_W-1:0] samp,
    output logic                    zpp
);

    localparam int HALF  = POS / 2;
    localparam int ZSTRT = POS - POS / 3;
    localparam int MAXS  = (2 ** SAMP_W) - 1;

    logic [SAMP_W-1:0] tab [QUART];

    for (genvar a = 0; a < QUART; a++) begin : g_tab
        localparam logic [SAMP_W-1:0] VAL = SAMP_W'(wsq_pkg::quarter_sample(a, QUART, MAXS));
        assign tab[a] = VAL;
    end

    logic              neg;
    logic [IDX_W-1:0]  fold;
    logic [IDX_W-1:0]  addr;
    logic [SAMP_W-1:0] mag;
    logic [P_W-1:0]    prod;
    logic [A_W-1:0]    scaled;

    always_comb begin
        neg    = (pos >= IDX_W'(HALF));
        fold   = neg ? pos - IDX_W'(HALF) : pos;
        addr   = (fold < IDX_W'(QUART)) ? fold : IDX_W'(HALF - 1) - fold;
        mag    = tab[addr[AW-1:0]];
        prod   = P_W'(mag) * P_W'(amp);
        scaled = A_W'(prod / P_W'(MAXS));
        samp   = neg ? -$signed({1'b0, scaled}) : $signed({1'b0, scaled});
        zpp    = (pos >= IDX_W'(ZSTRT));
    end

endmodule

// File: rtl/wsq_sequencer.sv
module wsq_sequencer #(
    parameter int POS     = 1536,
    parameter int QUART   = 384,
    parameter int PFS_W   = 12,
    parameter int AMP_W   = 8,
    parameter int SAMP_W  = 8,
    parameter int CODE_W  = 3,
    parameter int CFS_MAX = 5,
    parameter int FRS_MAX = 6,
    parameter int TRI_W   = 8,
    parameter int NPH     = 3,
    localparam int IDX_W  = $clog2(POS),
    localparam int A_W    = AMP_W + 1,
    localparam int OUT_W  = A_W + 1,
    localparam int LV_W   = OUT_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CODE_W-1:0]       cfs_code,
    input  logic [CODE_W-1:0]       frs_code,
    input  logic [PFS_W-1:0]        freq_word,
    input  logic                    dir_rev,
    input  logic [AMP_W-1:0]        amp_word,
    input  logic                    overmod,
    input  logic                    cnt_rst_n,
    output logic signed [OUT_W-1:0] samp_red,
    output logic signed [OUT_W-1:0] samp_yel,
    output logic signed [OUT_W-1:0] samp_blu,
    output logic [NPH-1:0]          pwm_raw,
    output logic [NPH-1:0]          zpp,
    output logic                    wss
);

    localparam int TMAX = (2 ** TRI_W) - 1;

    logic             tick, peak;
    logic [TRI_W-1:0] tri_val;
    logic [IDX_W-1:0] idx;
    logic [A_W-1:0]   amp9;

    assign amp9 = {overmod, amp_word};

    wsq_carrier #(.CODE_W(CODE_W), .CFS_MAX(CFS_MAX), .TRI_W(TRI_W)) u_carrier (
        .clk(clk), .rst_n(rst_n), .cfs(cfs_code),
        .tick(tick), .peak(peak), .tri_val(tri_val)
    );

    wsq_phase #(.PFS_W(PFS_W), .CODE_W(CODE_W), .FRS_MAX(FRS_MAX), .POS(POS),
                .CAR_LOG(TRI_W + 1), .QTR_LOG($clog2(POS / QUART))) u_phase (
        .clk(clk), .rst_n(rst_n), .tick(tick), .frs(frs_code), .pfs(freq_word),
        .dir_rev(dir_rev), .cnt_rst_n(cnt_rst_n), .idx(idx), .wss(wss)
    );

    logic signed [OUT_W-1:0] samp_a [NPH];
    logic [TRI_W-1:0]        lvl_a  [NPH];

    for (genvar k = 0; k < NPH; k++) begin : g_ph
        localparam int OFF = k * (POS / NPH);
        logic [IDX_W:0]          shifted;
        logic [IDX_W-1:0]        ppos;
        logic signed [LV_W-1:0]  lv;

        always_comb begin
            shifted = {1'b0, idx} + (IDX_W + 1)'(POS - OFF);
            ppos    = (shifted >= (IDX_W + 1)'(POS)) ? IDX_W'(shifted - (IDX_W + 1)'(POS))
                                                     : IDX_W'(shifted);
            lv      = (LV_W'(samp_a[k]) + LV_W'(TMAX + 1)) >>> 1;
            if (lv < 0)                  lvl_a[k] = '0;
            else if (lv > LV_W'(TMAX))   lvl_a[k] = '1;
            else                         lvl_a[k] = TRI_W'(lv);
        end

        wsq_shaper #(.QUART(QUART), .POS(POS), .SAMP_W(SAMP_W), .A_W(A_W)) u_shaper (
            .pos(ppos), .amp(amp9), .samp(samp_a[k]), .zpp(zpp[k])
        );

        assert_amp_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (samp_a[k] <= $signed({1'b0, amp9}) && samp_a[k] >= -$signed({1'b0, amp9})));
    end

    typedef struct packed {
        logic [NPH-1:0][TRI_W-1:0] hold;
        logic [NPH-1:0]            pwm;
    } cmp_t;

    cmp_t cmp_q, cmp_d;

    always_comb begin
        cmp_d = cmp_q;
        for (int k = 0; k < NPH; k++) begin
            if (peak) cmp_d.hold[k] = lvl_a[k];
            cmp_d.pwm[k] = (cmp_q.hold[k] > tri_val);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= '0;
        else        cmp_q <= cmp_d;
    end

    assign samp_red = samp_a[0];
    assign samp_yel = samp_a[1];
    assign samp_blu = samp_a[2];
    assign pwm_raw  = cmp_q.pwm;

    assert_one_marker_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(zpp) == 1);

endmodule

// File: tb/wsq_sequencer_tb.sv
module wsq_sequencer_tb;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] cfs = 3'd0, frs = 3'd6;
    logic [11:0] pfs = 12'd0;
    logic dir_rev = 1'b0, overmod = 1'b0, cnt_rst_n = 1'b0;
    logic [7:0] amp = 8'd255;
    logic signed [9:0] samp_red, samp_yel, samp_blu;
    logic [2:0] pwm_raw, zpp;
    logic wss;

    int checks = 0, fails = 0, pos = 0;
    bit done = 1'b0;
    logic prev_wss = 1'b0;

    always #5 clk = ~clk;

    wsq_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .cfs_code(cfs), .frs_code(frs), .freq_word(pfs),
        .dir_rev(dir_rev), .amp_word(amp), .overmod(overmod), .cnt_rst_n(cnt_rst_n),
        .samp_red(samp_red), .samp_yel(samp_yel), .samp_blu(samp_blu),
        .pwm_raw(pwm_raw), .zpp(zpp), .wss(wss)
    );

    function automatic int wrapp(input int p);
        return ((p % 1536) + 1536) % 1536;
    endfunction

    function automatic int exp_samp(input int p, input int a9);
        int q, a, m, v;
        q = (p >= 768) ? p - 768 : p;
        a = (q < 384) ? q : 767 - q;
        m = $rtoi(255.0 * $sin(1.5707963267948966 * real'(a) / 384.0) + 0.5);
        v = (m * a9) / 255;
        return (p >= 768) ? -v : v;
    endfunction

    function automatic int ph_pos(input int k);
        return wrapp(pos - 512 * k);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        int a9, ez;
        a9 = int'(overmod) * 256 + int'(amp);
        chk({req, " R4 R5 R8 red"}, int'(samp_red), exp_samp(ph_pos(0), a9));
        chk({req, " R6 yellow"},    int'(samp_yel), exp_samp(ph_pos(1), a9));
        chk({req, " R6 blue"},      int'(samp_blu), exp_samp(ph_pos(2), a9));
        ez = 0;
        for (int k = 0; k < 3; k++) if (ph_pos(k) >= 1024) ez |= (1 << k);
        chk({req, " R9 zpp"}, int'(zpp), ez);
    endtask

    task automatic park();
        @(negedge clk);
        cnt_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        pos = 0;
        prev_wss = wss;
    endtask

    task automatic sweep(input int n, input string req);
        logic d;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            d = dir_rev;
            @(negedge clk);
            if (wss !== prev_wss) begin
                prev_wss = wss;
                pos = d ? wrapp(pos - 1) : wrapp(pos + 1);
                check_all(req);
            end
        end
    endtask

    task automatic count_steps(input int c, input int f, input int p, input int k, input string req);
        int cnt, n, m;
        real e;
        cfs = 3'(c); frs = 3'(f); pfs = 12'(p);
        park();
        cnt_rst_n = 1'b1;
        cnt = 0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if (wss !== prev_wss) begin prev_wss = wss; cnt++; end
        end
        n = 1 << ((c > 5) ? 5 : c);
        m = 1 << ((f > 6) ? 6 : f);
        e = real'(k) * real'(p * m) / (524288.0 * real'(n));
        checks++;
        if (real'(cnt) - e > 1.5 || e - real'(cnt) > 1.5) begin
            fails++;
            $display("FAIL %s: actual %0d steps expected %0.2f", req, cnt, e);
        end
    endtask

    task automatic duty(input string req);
        int n, s, lv, a9;
        int hi [3];
        n = 1 << ((int'(cfs) > 5) ? 5 : int'(cfs));
        repeat (1100 * n) @(negedge clk);
        for (int k = 0; k < 3; k++) hi[k] = 0;
        for (int i = 0; i < 512 * n; i++) begin
            @(negedge clk);
            for (int k = 0; k < 3; k++) if (pwm_raw[k]) hi[k]++;
        end
        a9 = int'(overmod) * 256 + int'(amp);
        for (int k = 0; k < 3; k++) begin
            s  = exp_samp(ph_pos(k), a9);
            lv = (s + 256) >>> 1;
            if (lv < 0) lv = 0;
            if (lv > 255) lv = 255;
            chk(req, hi[k], 2 * lv * n);
        end
    endtask

    initial begin
        int ch;
        repeat (5) @(negedge clk);
        chk("R1 reset red sample", int'(samp_red), 0);
        chk("R1 R9 reset markers", int'(zpp), 3'b010);
        chk("R1 R10 reset wss", int'(wss), 0);
        chk("R1 R11 reset pwm", int'(pwm_raw), 0);
        pfs = 12'd4095; frs = 3'd6;
        rst_n = 1'b1;
        prev_wss = wss;
        ch = 0;
        repeat (60) begin
            @(negedge clk);
            if (wss !== prev_wss) ch++;
        end
        chk("R1 R10 no step under counter reset", ch, 0);
        chk("R1 red parked", int'(samp_red), 0);
        pos = 0;
        duty("R1 R11 parked duty");

        count_steps(0, 3, 1000, 10000, "R2 R10 step rate");
        count_steps(0, 7, 100, 10000, "R2 range code clamp");
        count_steps(1, 3, 1000, 10000, "R3 divide by 2");
        count_steps(7, 6, 4095, 10000, "R3 divide code clamp");

        cfs = 3'd0; frs = 3'd6; pfs = 12'd4095; amp = 8'd255; overmod = 1'b0; dir_rev = 1'b0;
        park();
        check_all("R1 parked");
        cnt_rst_n = 1'b1;
        sweep(3300, "fwd");
        dir_rev = 1'b1;
        sweep(1200, "R7 rev");
        dir_rev = 1'b0; amp = 8'd77; overmod = 1'b1;
        sweep(800, "R8 amp77 om");
        amp = 8'd255;
        sweep(500, "R8 full om");

        pfs = 12'd0; overmod = 1'b0; amp = 8'd200;
        duty("R11 frozen amp200");
        overmod = 1'b1; amp = 8'd255;
        duty("R11 overmod clamp");
        cfs = 3'd1; overmod = 1'b0; amp = 8'd120;
        duty("R3 R11 divided carrier");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule